// File: doc/BRIEF.md
# Transmit Byte-to-Word Packer

This block sits in front of a MAC transmit user interface. It takes frames as a stream of bytes, one byte per accepted transfer, and packs them into 32-bit words. Each word carries a frame-start flag, a frame-end flag and a 2-bit residual code that gives the number of valid bytes in the closing word of a frame. A byte flagged as the last byte ends the frame, so frame length needs no separate field, and frames of any length from one byte upward are packed correctly.

The byte side is a valid/ready interface. A byte moves on a rising edge where `byte_valid` and `byte_ready` are both high. The word side uses a write-allowed input from the MAC. A finished word waits in a holding register. `word_wr` is high exactly when a word is waiting and `mac_allow` is high, and the word moves on that edge. While the MAC blocks, the waiting word and its flags stay unchanged and `byte_ready` drops. When `mac_allow` is high, the waiting word drains in the same cycle that the next byte is taken, so one byte per cycle is kept up.

Top module: `tx_word_packer`

## Requirements
- R1: Bytes are packed big-endian. The first byte of each group of four goes to bits [31:24], the second to [23:16], the third to [15:8] and the fourth to [7:0].
- R2: On the word with `word_eop` high, `word_be` is 2'b01, 2'b10 or 2'b11 when the word holds 1, 2 or 3 valid bytes, and 2'b00 when it holds 4.
- R3: Every word with `word_eop` low has `word_be` equal to 2'b00.
- R4: `word_sop` is high only on the first word of a frame. `word_eop` is high only on the word that holds the frame's last byte. A one-byte frame gives one word with both flags high and `word_be` = 2'b01.
- R5: `word_wr` is low in every cycle where `mac_allow` is low. A waiting word keeps its data, flags and code unchanged until it is written.
- R6: `byte_ready` is low while a finished word waits and `mac_allow` is low. It is high when no word waits or when `mac_allow` is high.
- R7: In a closing word with fewer than four valid bytes, the unused low-order byte lanes are zero.
- R8: A byte with `byte_sof` high always begins a new word in lane [31:24] with `word_sop` high. Any bytes gathered for an unfinished word are dropped. Words already written are not affected.
- R9: Synchronous active-high `rst` drops any partial word and any waiting word, and makes the next byte start a frame. After reset `word_wr` is low and `byte_ready` is high.
- R10: With `mac_allow` held high, a byte is accepted in every cycle that `byte_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| byte_valid | input | 1 | Byte offered |
| byte_ready | output | 1 | Byte can be accepted this cycle |
| byte_data | input | 8 | Byte value |
| byte_sof | input | 1 | Byte is the first of a frame |
| byte_eof | input | 1 | Byte is the last of a frame |
| mac_allow | input | 1 | MAC can take a word this cycle |
| word_wr | output | 1 | Word is written this cycle |
| word_data | output | 32 | Packed word, first byte in the top lane |
| word_sop | output | 1 | Word starts a frame |
| word_eop | output | 1 | Word ends a frame |
| word_be | output | 2 | Valid-byte count of a closing word (00 means four) |

## Verification
The bench builds the block with its default parameters: four 8-bit lanes, which gives a 32-bit word and a 2-bit residual code. With these values, frame lengths of 1 to 16 bytes cover every residue of the code, including both wrap cases (00 on a full closing word and 00 on inner words). Write-allowed patterns that change every cycle make words wait for one or several cycles. Directed cases cover a restart in mid-frame, a reset in mid-frame, and a full word held back while bytes keep arriving.

// File: rtl/tx_packer_pkg.sv
package tx_packer_pkg;

  // Default geometry: four byte lanes in a 32-bit word.
  localparam int unsigned PK_LANES  = 4;
  localparam int unsigned PK_BYTE_W = 8;

  // Frame flags carried alongside each packed word.
  typedef struct packed {
    logic sop;
    logic eop;
  } frame_flags_t;

endpackage

// File: rtl/tx_packer_gather.sv
module tx_packer_gather #(
  parameter int unsigned LANES  = tx_packer_pkg::PK_LANES,
  parameter int unsigned BYTE_W = tx_packer_pkg::PK_BYTE_W,
  localparam int unsigned IDX_W  = $clog2(LANES),
  localparam int unsigned WORD_W = LANES * BYTE_W
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        take,
  input  logic [BYTE_W-1:0]           byte_in,
  input  logic                        sof_in,
  input  logic                        last_in,
  output logic                        word_done,
  output logic [WORD_W-1:0]           word_data,
  output tx_packer_pkg::frame_flags_t word_flags,
  output logic [IDX_W-1:0]            word_be
);

  logic [IDX_W-1:0] idx_q;
  logic             sop_pend_q;
  logic [IDX_W-1:0] idx_eff;

  // A start marker always places its byte in lane 0.
  assign idx_eff = sof_in ? '0 : idx_q;

  // Lanes 0 .. LANES-2 are stored; the last lane comes straight from the input.
  logic [BYTE_W-1:0] lane_q [LANES-1];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam int unsigned HI = WORD_W - 1 - l * BYTE_W;
    if (l < LANES - 1) begin : g_stored
      always_ff @(posedge clk) begin
        if (take && (idx_eff == IDX_W'(l))) begin
          lane_q[l] <= byte_in;
        end
      end
      always_comb begin
        if (idx_eff == IDX_W'(l)) begin
          word_data[HI -: BYTE_W] = byte_in;
        end else if (IDX_W'(l) < idx_eff) begin
          word_data[HI -: BYTE_W] = lane_q[l];
        end else begin
          word_data[HI -: BYTE_W] = '0;
        end
      end
    end else begin : g_tail
      always_comb begin
        word_data[HI -: BYTE_W] = (idx_eff == IDX_W'(l)) ? byte_in : '0;
      end
    end
  end

  assign word_done      = take && (last_in || (idx_eff == IDX_W'(LANES - 1)));
  assign word_flags.sop = sop_pend_q || sof_in;
  assign word_flags.eop = last_in;
  // Count of valid bytes modulo the lane count: a full word wraps to zero.
  assign word_be        = last_in ? (idx_eff + IDX_W'(1)) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q      <= '0;
      sop_pend_q <= 1'b1;
    end else if (take) begin
      if (word_done) begin
        idx_q      <= '0;
        sop_pend_q <= last_in;
      end else begin
        idx_q      <= idx_eff + IDX_W'(1);
        sop_pend_q <= sop_pend_q || sof_in;
      end
    end
  end

endmodule

// File: rtl/tx_packer_hold.sv
module tx_packer_hold #(
  parameter int unsigned LANES  = tx_packer_pkg::PK_LANES,
  parameter int unsigned BYTE_W = tx_packer_pkg::PK_BYTE_W,
  localparam int unsigned IDX_W  = $clog2(LANES),
  localparam int unsigned WORD_W = LANES * BYTE_W
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        load,
  input  logic [WORD_W-1:0]           load_data,
  input  tx_packer_pkg::frame_flags_t load_flags,
  input  logic [IDX_W-1:0]            load_be,
  input  logic                        allow,
  output logic                        full,
  output logic [WORD_W-1:0]           held_data,
  output tx_packer_pkg::frame_flags_t held_flags,
  output logic [IDX_W-1:0]            held_be
);

  always_ff @(posedge clk) begin
    if (rst) begin
      full       <= 1'b0;
      held_data  <= '0;
      held_flags <= '0;
      held_be    <= '0;
    end else if (load) begin
      full       <= 1'b1;
      held_data  <= load_data;
      held_flags <= load_flags;
      held_be    <= load_be;
    end else if (full && allow) begin
      full <= 1'b0;
    end
  end

endmodule

// File: rtl/tx_word_packer.sv
module tx_word_packer #(
  parameter int unsigned LANES  = tx_packer_pkg::PK_LANES,
  parameter int unsigned BYTE_W = tx_packer_pkg::PK_BYTE_W,
  localparam int unsigned IDX_W  = $clog2(LANES),
  localparam int unsigned WORD_W = LANES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_valid,
  output logic              byte_ready,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              byte_sof,
  input  logic              byte_eof,
  input  logic              mac_allow,
  output logic              word_wr,
  output logic [WORD_W-1:0] word_data,
  output logic              word_sop,
  output logic              word_eop,
  output logic [IDX_W-1:0]  word_be
);

  logic                        hold_v;
  logic                        take;
  logic                        done;
  logic [WORD_W-1:0]           asm_data;
  tx_packer_pkg::frame_flags_t asm_flags;
  logic [IDX_W-1:0]            asm_be;
  tx_packer_pkg::frame_flags_t out_flags;

  // A waiting word that drains this cycle frees the holding register.
  assign byte_ready = !hold_v || mac_allow;
  assign take       = byte_valid && byte_ready;

  tx_packer_gather #(.LANES(LANES), .BYTE_W(BYTE_W)) u_gather (
    .clk        (clk),
    .rst        (rst),
    .take       (take),
    .byte_in    (byte_data),
    .sof_in     (byte_sof),
    .last_in    (byte_eof),
    .word_done  (done),
    .word_data  (asm_data),
    .word_flags (asm_flags),
    .word_be    (asm_be)
  );

  tx_packer_hold #(.LANES(LANES), .BYTE_W(BYTE_W)) u_hold (
    .clk        (clk),
    .rst        (rst),
    .load       (done),
    .load_data  (asm_data),
    .load_flags (asm_flags),
    .load_be    (asm_be),
    .allow      (mac_allow),
    .full       (hold_v),
    .held_data  (word_data),
    .held_flags (out_flags),
    .held_be    (word_be)
  );

  assign word_wr  = hold_v && mac_allow;
  assign word_sop = out_flags.sop;
  assign word_eop = out_flags.eop;

endmodule

// File: rtl/tx_word_packer_chk.sv
module tx_word_packer_chk #(
  parameter int unsigned LANES  = tx_packer_pkg::PK_LANES,
  parameter int unsigned BYTE_W = tx_packer_pkg::PK_BYTE_W,
  localparam int unsigned IDX_W  = $clog2(LANES),
  localparam int unsigned WORD_W = LANES * BYTE_W
) (
  input logic              clk,
  input logic              rst,
  input logic              byte_ready,
  input logic              mac_allow,
  input logic              word_wr,
  input logic [WORD_W-1:0] word_data,
  input logic              word_sop,
  input logic              word_eop,
  input logic [IDX_W-1:0]  word_be,
  input logic              hold_v
);

  logic              after_eop_q;
  logic [WORD_W-1:0] pad_mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      after_eop_q <= 1'b1;
    end else if (word_wr) begin
      after_eop_q <= word_eop;
    end
  end

  always_comb begin
    pad_mask = '0;
    for (int l = 0; l < LANES; l++) begin
      if ((word_be != '0) && (IDX_W'(l) >= word_be)) begin
        pad_mask[WORD_W - 1 - l * BYTE_W -: BYTE_W] = '1;
      end
    end
  end

  p_stall_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (hold_v && !mac_allow) |=> (hold_v && $stable(word_data) && $stable(word_sop)
                                && $stable(word_eop) && $stable(word_be)));

  p_no_wr_blocked_r5: assert property (@(posedge clk) disable iff (rst)
    !mac_allow |-> !word_wr);

  p_ready_blocked_r6: assert property (@(posedge clk) disable iff (rst)
    (hold_v && !mac_allow) |-> !byte_ready);

  p_inner_be_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (word_wr && !word_eop) |-> (word_be == '0));

  p_sop_after_eop_r4: assert property (@(posedge clk) disable iff (rst)
    (word_wr && after_eop_q) |-> word_sop);

  p_pad_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (word_wr && word_eop) |-> ((word_data & pad_mask) == '0));

endmodule

bind tx_word_packer tx_word_packer_chk #(.LANES(LANES), .BYTE_W(BYTE_W)) u_chk (.*);

// File: tb/tx_word_packer_test.sv
`timescale 1ns/1ps
module tx_word_packer_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        byte_valid = 1'b0;
  logic        byte_ready;
  logic [7:0]  byte_data = '0;
  logic        byte_sof = 1'b0;
  logic        byte_eof = 1'b0;
  logic        mac_allow = 1'b0;
  logic        word_wr;
  logic [31:0] word_data;
  logic        word_sop;
  logic        word_eop;
  logic [1:0]  word_be;

  always #2.5 clk = ~clk;

  tx_word_packer uut (.*);

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int nready = 0;
  logic [7:0] allow_pat = 8'h00;

  // Expected words: {sop, eop, be, data}
  logic [35:0] exp_q [0:255];
  int wr_p = 0;
  int rd_p = 0;

  // Table: {length[15:0], first byte[7:0], write-allowed pattern[7:0]}
  localparam logic [31:0] VEC [10] = '{
    {16'd1,  8'h10, 8'hFF}, {16'd2,  8'h20, 8'hFF}, {16'd3,  8'h30, 8'h5A},
    {16'd4,  8'h40, 8'hFF}, {16'd5,  8'h50, 8'h33}, {16'd7,  8'h60, 8'h0F},
    {16'd8,  8'h70, 8'hFF}, {16'd13, 8'h80, 8'h6D}, {16'd16, 8'h90, 8'hFF},
    {16'd6,  8'hC0, 8'h81}
  };

  always @(negedge clk) begin
    cyc++;
    mac_allow = allow_pat[cyc % 8];
  end

  task automatic check(input bit ok, input string msg, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
    end
  endtask

  // Monitor: every written word is compared with the model (R1 R2 R3 R4 R7), and no write while blocked (R5).
  always @(negedge clk) begin
    #2;
    if (!rst) begin
      if (!mac_allow && word_wr) check(1'b0, "R5 write while blocked", 64'(word_wr), 64'd0);
      if (word_wr) begin
        if (rd_p >= wr_p) check(1'b0, "R4 unexpected word", 64'(word_data), 64'd0);
        else begin
          check({word_sop, word_eop, word_be, word_data} === exp_q[rd_p],
                "R1 R2 R3 R4 R7 word", 64'({word_sop, word_eop, word_be, word_data}), 64'(exp_q[rd_p]));
          rd_p++;
        end
      end
    end
  end

  task automatic push_frame(input int len, input logic [7:0] seed);
    for (int w = 0; w < (len + 3) / 4; w++) begin
      logic [31:0] d;
      logic        last;
      d = '0;
      for (int b = 0; b < 4; b++)
        if (w * 4 + b < len) d[31 - 8 * b -: 8] = seed + 8'(w * 4 + b);
      last = (w == (len + 3) / 4 - 1);
      exp_q[wr_p] = {w == 0, last, last ? 2'(len % 4) : 2'b00, d};
      wr_p++;
    end
  endtask

  task automatic send_byte(input logic [7:0] d, input bit sof, input bit eof);
    bit done;
    done = 0;
    @(negedge clk);
    byte_valid = 1'b1; byte_data = d; byte_sof = sof; byte_eof = eof;
    while (!done) begin
      #1;
      if (byte_ready) done = 1; else nready++;
      @(posedge clk);
      if (!done) @(negedge clk);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    byte_valid = 1'b0; byte_sof = 1'b0; byte_eof = 1'b0;
  endtask

  task automatic send_frame(input int len, input logic [7:0] seed, input bit sof);
    for (int i = 0; i < len; i++) send_byte(seed + 8'(i), sof && (i == 0), i == len - 1);
    idle();
  endtask

  task automatic drain();
    allow_pat = 8'hFF;
    repeat (8) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    check(1'b0, "R9 watchdog expired", 64'd0, 64'd1);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(word_wr === 1'b0, "R9 reset word_wr", 64'(word_wr), 64'd0);
    @(negedge clk); rst = 1'b0;
    #1;
    check(byte_ready === 1'b1, "R9 ready after reset", 64'(byte_ready), 64'd1);

    // Table walk
    for (int v = 0; v < 10; v++) begin
      int len;
      len = int'(VEC[v][31:16]);
      allow_pat = VEC[v][7:0];
      push_frame(len, VEC[v][15:8]);
      nready = 0;
      send_frame(len, VEC[v][15:8], (v % 2) == 0);
      if (VEC[v][7:0] == 8'hFF)
        check(nready == 0, "R10 ready stalls at full allow", 64'(nready), 64'd0);
      drain();
    end

    // R6 / R5: a full word waits while blocked
    allow_pat = 8'h00;
    push_frame(4, 8'hA0);
    send_frame(4, 8'hA0, 1'b1);
    #1;
    check(byte_ready === 1'b0, "R6 ready low while word waits", 64'(byte_ready), 64'd0);
    check(word_data === 32'hA0A1A2A3, "R5 held data", 64'(word_data), 64'hA0A1A2A3);
    repeat (3) @(negedge clk);
    #1;
    check(word_data === 32'hA0A1A2A3 && word_eop === 1'b1 && word_be === 2'b00,
          "R5 held after stall", 64'({word_eop, word_be, word_data}), 64'({1'b1, 2'b00, 32'hA0A1A2A3}));
    allow_pat = 8'hFF;
    @(negedge clk); #1;
    check(byte_ready === 1'b1, "R6 ready with allow high", 64'(byte_ready), 64'd1);
    drain();

    // R8: restart marker after six bytes; first word stays, two partial bytes dropped
    allow_pat = 8'hFF;
    exp_q[wr_p] = {1'b1, 1'b0, 2'b00, 32'h11121314}; wr_p++;
    for (int i = 0; i < 6; i++) send_byte(8'h11 + 8'(i), i == 0, 1'b0);
    push_frame(5, 8'hE0);
    send_frame(5, 8'hE0, 1'b1);
    drain();

    // R9: reset in mid-frame, next byte starts a clean one-byte frame (R4)
    send_byte(8'h55, 1'b1, 1'b0);
    send_byte(8'h56, 1'b0, 1'b0);
    idle();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    exp_q[wr_p] = {1'b1, 1'b1, 2'b01, 32'h77000000}; wr_p++;
    send_byte(8'h77, 1'b0, 1'b1);
    idle();
    drain();

    check(rd_p == wr_p, "R4 all expected words written", 64'(rd_p), 64'(wr_p));
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule